// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside the fetch and execute stages of a small single-issue microcontroller core. It chooses among several interrupt request lines and a reset request, and it gives the core a program vector address to jump to. Every source has its own vector at the bottom of program memory. Reset uses index 0. Source k, which arrives on request bit k-1, uses index k. A lower index gives a higher priority. The block also holds the global interrupt enable bit. The hardware clears this bit when an interrupt is accepted. A return-from-interrupt sets it again, and software may set it early inside a handler so that other sources can preempt that handler.

The core raises `at_boundary` on each cycle where it can give up control at an instruction boundary. On the next cycle the block answers with a single-cycle `take_pulse` and a registered `vector_addr`. The block never clears a request line. Any lower-priority requests that are still pending therefore compete again at a later boundary.

Top module: `vint_ctrl`

## Requirements
- R1: The vector address for index n is n × VEC_STEP (default 1). Reset is index 0, and request bit k-1 (source k) is index k. Bit 0 is external request 0 at index 1.
- R2: A source is accepted only when its bit in `src_enable` and the global enable `gie` are both 1.
- R3: If several enabled sources are pending, the lowest index is accepted. The other sources are not cleared and can be accepted later.
- R4: A rising edge on `reset_req` produces `take_pulse` on the next cycle with vector 0. This ignores every enable and `at_boundary`. While `reset_req` is high, `gie` is forced to 0.
- R5: Accepting an interrupt clears `gie` to 0 in the same edge that raises `take_pulse`.
- R6: An interrupt source is accepted only in a cycle where `at_boundary` is 1.
- R7: A `reti_strobe` sets `gie` to 1 on the next cycle.
- R8: `take_pulse` is registered. It rises one cycle after the accepting cycle and lasts exactly one cycle. `vector_addr` changes only when a take is loaded, so it holds its value through and after the pulse.
- R9: The update of `gie` follows a fixed precedence: reset request, then acceptance, then `reti_strobe`, then software write. For example, an acceptance and a software write of 1 in the same cycle leave `gie` at 0.
- R10: A software write (`gie_wr_en`, `gie_wr_data`) sets `gie` on the next cycle. Writing 1 inside a handler lets a new acceptance take place, which is nesting.
- R11: A synchronous active-low `rst_n` clears `take_pulse`, `vector_addr` and `gie` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Reset request, taken on its rising edge |
| src_pending | input | N_SRC | Request lines; bit k-1 is source k |
| src_enable | input | N_SRC | Per-source enable mask |
| at_boundary | input | 1 | Core is at an instruction boundary and can take an interrupt |
| reti_strobe | input | 1 | Return-from-interrupt executed |
| gie_wr_en | input | 1 | Software write strobe for the global enable |
| gie_wr_data | input | 1 | Value written to the global enable |
| take_pulse | output | 1 | One-cycle request to jump to `vector_addr` |
| vector_addr | output | VEC_W | Vector address of the last accepted source |
| gie | output | 1 | Current global interrupt enable |

## Verification
Two events can fall in the same clock cycle: the hardware clear of `gie` on acceptance and a software write of `gie`. A return-from-interrupt and a software write of 0 can also coincide. The bench provokes both collisions by driving `at_boundary` with a pending, enabled source and the write strobe together, and separately by driving `reti_strobe` together with a write of 0. It then reads `gie` one cycle later and judges the result against the precedence order in R9. The bench also raises a reset request while a software write is under way. It checks that the reset request wins.

// File: rtl/vint_pkg.sv
// vint_pkg: shared helpers for the vectored interrupt controller.
// Assumes vector addresses fit in 32 bits before truncation at the top.
package vint_pkg;

    // Vector address of a given index for a given word spacing.
    function automatic int unsigned vint_vec_of(input int unsigned idx,
                                                input int unsigned step);
        return idx * step;
    endfunction

endpackage

// File: rtl/vint_arbiter.sv
// vint_arbiter: fixed-priority selector over the masked request lines.
// Request bit g corresponds to index g+1; index 0 is reserved for reset.
// Assumes inputs are already synchronous to clk. Purely combinational;
// clk and rst_n serve the local assertion only.
module vint_arbiter #(
    parameter int N_SRC = 4,
    parameter int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [N_SRC-1:0] req;

    // Per-source gating by the individual enable bit.
    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_mask
            assign req[g] = pend[g] & en[g];
        end
    endgenerate

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i + 1);
        end
    end

    // R3: the chosen index is requested and no lower index is requested.
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (((req & ((N_SRC'(1) << (idx - 1'b1)) - N_SRC'(1))) == '0)
                 && (((req >> (idx - 1'b1)) & N_SRC'(1)) != '0)))
        else $error("p_lowest_wins_r3");

endmodule

// File: rtl/vint_gie.sv
// vint_gie: the global interrupt enable flip-flop.
// Precedence: reset request > acceptance > return > software write.
// Assumes all strobes are single-cycle and synchronous to clk.
module vint_gie (
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr,
    input  logic take_clr,
    input  logic reti_set,
    input  logic sw_wr,
    input  logic sw_data,
    output logic gie
);

    // Update the enable bit according to the fixed precedence ladder.
    always_ff @(posedge clk) begin
        if (!rst_n)          gie <= 1'b0;
        else if (force_clr)  gie <= 1'b0;
        else if (take_clr)   gie <= 1'b0;
        else if (reti_set)   gie <= 1'b1;
        else if (sw_wr)      gie <= sw_data;
    end

    // R7: a return with no higher-ranked event sets the enable.
    p_reti_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_set && !force_clr && !take_clr) |=> gie)
        else $error("p_reti_sets_r7");

    // R9: an acceptance beats any software write in the same cycle.
    p_take_beats_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_clr && sw_wr) |=> !gie)
        else $error("p_take_beats_write_r9");

    // R10: a lone software write lands next cycle.
    p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !force_clr && !take_clr && !reti_set) |=> (gie == $past(sw_data)))
        else $error("p_sw_write_r10");

endmodule

// File: rtl/vint_ctrl.sv
// vint_ctrl: vectored priority interrupt controller top.
// Accepts the highest-priority enabled source at an instruction boundary
// while the global enable is set, or a reset request on its rising edge,
// and issues a registered one-cycle take pulse with the vector address.
// Assumes request lines are held by their sources until software clears them.
module vint_ctrl #(
    parameter int N_SRC    = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_req,
    input  logic [N_SRC-1:0] src_pending,
    input  logic [N_SRC-1:0] src_enable,
    input  logic             at_boundary,
    input  logic             reti_strobe,
    input  logic             gie_wr_en,
    input  logic             gie_wr_data,
    output logic             take_pulse,
    output logic [VEC_W-1:0] vector_addr,
    output logic             gie
);
    import vint_pkg::*;

    localparam int IDX_W = $clog2(N_SRC + 1);

    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic             rreq_q;
    logic             rst_rise;
    logic             accept;

    vint_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (src_pending),
        .en    (src_enable),
        .any   (any_req),
        .idx   (win_idx)
    );

    // Edge of reset request and gated acceptance of a source.
    always_comb begin
        rst_rise = reset_req & ~rreq_q;
        accept   = at_boundary & gie & any_req & ~reset_req;
    end

    vint_gie gie_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_clr (reset_req),
        .take_clr  (accept),
        .reti_set  (reti_strobe),
        .sw_wr     (gie_wr_en),
        .sw_data   (gie_wr_data),
        .gie       (gie)
    );

    // Register the take pulse, the vector and the reset-request history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rreq_q      <= 1'b0;
            take_pulse  <= 1'b0;
            vector_addr <= '0;
        end else begin
            rreq_q     <= reset_req;
            take_pulse <= rst_rise | accept;
            if (rst_rise)
                vector_addr <= '0;
            else if (accept)
                vector_addr <= VEC_W'(vint_vec_of(32'(win_idx), VEC_STEP));
        end
    end

    // R2: a non-reset take needs the enable set in the accepting cycle.
    p_gated_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pulse && vector_addr != '0) |-> $past(gie))
        else $error("p_gated_take_r2");

    // R6: a non-reset take needs the boundary strobe in the accepting cycle.
    p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pulse && vector_addr != '0) |-> $past(at_boundary))
        else $error("p_boundary_r6");

    // R5: the enable is low while the take pulse is high.
    p_clear_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> !gie)
        else $error("p_clear_on_take_r5");

    // R8: the take pulse is exactly one cycle wide.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |=> !take_pulse)
        else $error("p_single_pulse_r8");

    // R8: the vector only moves together with a take pulse.
    p_vec_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_pulse |-> $stable(vector_addr))
        else $error("p_vec_stable_r8");

    // R4: a reset request edge yields a take to vector 0.
    p_reset_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |=> (take_pulse && vector_addr == '0))
        else $error("p_reset_vec_r4");

endmodule

// File: tb/vint_ctrl_tb.sv
// vint_ctrl_tb_top: table walk of arbitration cases, then directed tests.
module vint_ctrl_tb_top;

    localparam int N_SRC = 4;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reset_req = 1'b0;
    logic [N_SRC-1:0] src_pending = '0;
    logic [N_SRC-1:0] src_enable = '0;
    logic             at_boundary = 1'b0;
    logic             reti_strobe = 1'b0;
    logic             gie_wr_en = 1'b0;
    logic             gie_wr_data = 1'b0;
    logic             take_pulse;
    logic [VEC_W-1:0] vector_addr;
    logic             gie;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vint_ctrl #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_STEP(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
        .src_pending(src_pending), .src_enable(src_enable),
        .at_boundary(at_boundary), .reti_strobe(reti_strobe),
        .gie_wr_en(gie_wr_en), .gie_wr_data(gie_wr_data),
        .take_pulse(take_pulse), .vector_addr(vector_addr), .gie(gie)
    );

    // {pending[3:0], enable[3:0], expected take, expected vector[7:0]}
    localparam logic [16:0] TBL [8] = '{
        {4'b0001, 4'b1111, 1'b1, 8'd1},
        {4'b1010, 4'b1111, 1'b1, 8'd2},
        {4'b1100, 4'b1111, 1'b1, 8'd3},
        {4'b1000, 4'b1111, 1'b1, 8'd4},
        {4'b1111, 4'b1110, 1'b1, 8'd2},
        {4'b0101, 4'b1010, 1'b0, 8'd2},
        {4'b0000, 4'b1111, 1'b0, 8'd2},
        {4'b1111, 4'b1111, 1'b1, 8'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Write the global enable in one cycle.
    task automatic write_gie(input bit v);
        @(negedge clk);
        gie_wr_en = 1'b1; gie_wr_data = v;
        @(negedge clk);
        gie_wr_en = 1'b0;
    endtask

    // One boundary cycle with the given requests; outputs sampled after the edge.
    task automatic boundary(input logic [3:0] p, input logic [3:0] e);
        src_pending = p; src_enable = e; at_boundary = 1'b1;
        @(negedge clk);
        at_boundary = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk_eq("R11 take", int'(take_pulse), 0);
        chk_eq("R11 vec", int'(vector_addr), 0);
        chk_eq("R11 gie", int'(gie), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: global enable low blocks acceptance
        boundary(4'b1111, 4'b1111);
        chk_eq("R2 gie low no take", int'(take_pulse), 0);

        // R10: software write sets gie
        write_gie(1'b1);
        chk_eq("R10 write gie", int'(gie), 1);

        // R6: no boundary strobe, no acceptance
        src_pending = 4'b1111; src_enable = 4'b1111;
        @(negedge clk);
        chk_eq("R6 no boundary take", int'(take_pulse), 0);
        chk_eq("R6 gie kept", int'(gie), 1);

        // R1 R2 R3 R5: table walk
        for (int i = 0; i < 8; i++) begin
            write_gie(1'b1);
            boundary(TBL[i][16:13], TBL[i][12:9]);
            chk_eq($sformatf("R3 take row %0d", i), int'(take_pulse), int'(TBL[i][8]));
            chk_eq($sformatf("R1 vec row %0d", i), int'(vector_addr), int'(TBL[i][7:0]));
            chk_eq($sformatf("R5 gie row %0d", i), int'(gie), int'(!TBL[i][8]));
            src_pending = '0;
        end

        // R8: pulse one cycle wide, vector held, boundary kept high
        write_gie(1'b1);
        src_pending = 4'b0001; src_enable = 4'b1111; at_boundary = 1'b1;
        @(negedge clk);
        chk_eq("R8 take rises", int'(take_pulse), 1);
        @(negedge clk);
        chk_eq("R8 take one cycle", int'(take_pulse), 0);
        chk_eq("R8 vec held", int'(vector_addr), 1);
        at_boundary = 1'b0;

        // R10: nesting after early enable inside the handler
        write_gie(1'b1);
        boundary(4'b0010, 4'b1111);
        chk_eq("R10 nested take", int'(take_pulse), 1);
        chk_eq("R10 nested vec", int'(vector_addr), 2);

        // R7: return sets gie
        reti_strobe = 1'b1;
        @(negedge clk);
        reti_strobe = 1'b0;
        chk_eq("R7 reti gie", int'(gie), 1);

        // R9: acceptance and software write of 1 together
        src_pending = 4'b0001; src_enable = 4'b1111;
        at_boundary = 1'b1; gie_wr_en = 1'b1; gie_wr_data = 1'b1;
        @(negedge clk);
        at_boundary = 1'b0; gie_wr_en = 1'b0;
        chk_eq("R9 take in collision", int'(take_pulse), 1);
        chk_eq("R9 clear beats write", int'(gie), 0);

        // R9: return and software write of 0 together
        reti_strobe = 1'b1; gie_wr_en = 1'b1; gie_wr_data = 1'b0;
        @(negedge clk);
        reti_strobe = 1'b0; gie_wr_en = 1'b0;
        chk_eq("R9 reti beats write", int'(gie), 1);

        // R3: lower source still pending is taken after the winner is served
        boundary(4'b0011, 4'b1111);
        chk_eq("R3 first winner", int'(vector_addr), 1);
        write_gie(1'b1);
        boundary(4'b0010, 4'b1111);
        chk_eq("R3 loser later", int'(take_pulse), 1);
        chk_eq("R3 loser vec", int'(vector_addr), 2);
        src_pending = '0;

        // R4: reset request ignores enables and boundary, clears gie
        write_gie(1'b1);
        src_enable = '0; reset_req = 1'b1;
        @(negedge clk);
        chk_eq("R4 reset take", int'(take_pulse), 1);
        chk_eq("R4 reset vec", int'(vector_addr), 0);
        chk_eq("R4 reset gie", int'(gie), 0);
        gie_wr_en = 1'b1; gie_wr_data = 1'b1;
        @(negedge clk);
        gie_wr_en = 1'b0;
        chk_eq("R4 held no second take", int'(take_pulse), 0);
        chk_eq("R4 write blocked", int'(gie), 0);
        reset_req = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
    end

endmodule